// File: doc/BRIEF.md
# Cross-Clock Global Control Register

This block holds the global reset and enable word of a serial audio port. A CPU writes it on a fast bus clock. Its bits are split into a receive half and a transmit half. Each half is used in its own slow bit-clock domain. Bit 0 of each half is the release bit for that direction's frame-sync generator. The remaining bits are further per-direction control bits that pass through unchanged.

Three addresses reach the word:
- The combined address writes both halves together.
- The receive alias writes only the receive half.
- The transmit alias writes only the transmit half.

Both aliases read back the freshly written value right away, as a debug view. The combined address reads back a confirmed copy instead. That copy is refreshed only after the destination bit-clock domain has captured the new value and the capture has been sent back across to the bus clock.

Software that needs to know a half has taken effect polls the combined address. Because a stopped bit clock stalls confirmation for as long as it stays stopped, such polling needs a timeout.

Top module: `xclk_gctl`

## Requirements
- R1: While `bus_rst_n` is low, the written copy and the confirmed copy are both zero. After it is released, every address reads zero until the first write.
- R2: `tx_rst_n` clears `tx_ctl` and `rx_rst_n` clears `rx_ctl`. Each reset acts without affecting the other direction's output.
- R3: A write to address 0 (combined) loads the receive half from `wdata[HALF_W-1:0]` and the transmit half from `wdata[2*HALF_W-1:HALF_W]`.
- R4: A write to address 1 changes only the receive half, and a write to address 2 changes only the transmit half. Each alias takes its bits from the same positions as the combined layout, and the other half keeps its value.
- R5: Reading address 1 or address 2 returns the full written word, including the effect of a write from the first bus clock edge after that write's edge onward.
- R6: A half reaches its `tx_ctl` or `rx_ctl` output on the second rising edge of that domain's bit clock after the write. After only one such edge, the output still holds its old value.
- R7: After a destination output changes, the matching half of the address 0 readback changes on the second rising `bus_clk` edge that follows. After one edge it still shows the old value.
- R8: While a destination bit clock is stopped, that half of the address 0 readback keeps its old value for any number of bus cycles.
- R9: When a half is written again before an earlier value has crossed, the later value wins. The output and the address 0 readback settle to the latest value. With no write, the written copy holds.
- R10: Writes to address 3 change nothing, and reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low bus reset |
| wr_en | input | 1 | Write strobe, sampled on the `bus_clk` rising edge |
| addr | input | 2 | 0 combined, 1 receive alias, 2 transmit alias, 3 unused |
| wdata | input | 8 | Write data; receive half in the low bits, transmit half in the high bits |
| rdata | output | 8 | Combinational read data for `addr` |
| tx_clk | input | 1 | Transmit bit clock |
| tx_rst_n | input | 1 | Asynchronous active-low transmit-domain reset |
| tx_ctl | output | 4 | Transmit half in the `tx_clk` domain |
| rx_clk | input | 1 | Receive bit clock |
| rx_rst_n | input | 1 | Asynchronous active-low receive-domain reset |
| rx_ctl | output | 4 | Receive half in the `rx_clk` domain |

## Verification
A new bus write can land in the same bus cycle as an acknowledge that updates the confirmed copy with an older value. The readback must then end on the latest write, not the stale one. The bench provokes this by issuing random writes at random gaps while both bit clocks run freely at rates unrelated to the bus clock, so writes keep arriving during crossings that are still in flight. It judges each write by comparing the alias readback with a bench model right away. At regular points it lets the crossings settle and requires the combined readback and both destination outputs to equal the model.

// File: rtl/xclk_gctl.sv
module xclk_gctl #(
  parameter int HALF_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  bus_clk,
  input  logic                  bus_rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0]   rdata,
  input  logic                  tx_clk,
  input  logic                  tx_rst_n,
  output logic [HALF_W-1:0]     tx_ctl,
  input  logic                  rx_clk,
  input  logic                  rx_rst_n,
  output logic [HALF_W-1:0]     rx_ctl
);
  localparam int DW = 2 * HALF_W;
  localparam int CW = SYNC_STAGES * HALF_W;

  logic [DW-1:0] shadow;
  logic [DW-1:0] conf;
  logic [DW-1:0] dst_all;
  logic [1:0]    dclk;
  logic [1:0]    drst_n;

  assign dclk   = {tx_clk, rx_clk};
  assign drst_n = {tx_rst_n, rx_rst_n};

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      shadow <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: shadow <= wdata;
        2'd1: shadow[HALF_W-1:0] <= wdata[HALF_W-1:0];
        2'd2: shadow[DW-1:HALF_W] <= wdata[DW-1:HALF_W];
        default: ;
      endcase
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [CW-1:0] fwd;
    logic [CW-1:0] ack;

    always_ff @(posedge dclk[h] or negedge drst_n[h]) begin
      if (!drst_n[h]) fwd <= '0;
      else            fwd <= {fwd[CW-HALF_W-1:0], shadow[h*HALF_W +: HALF_W]};
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) ack <= '0;
      else            ack <= {ack[CW-HALF_W-1:0], fwd[CW-1 -: HALF_W]};
    end

    assign dst_all[h*HALF_W +: HALF_W] = fwd[CW-1 -: HALF_W];
    assign conf[h*HALF_W +: HALF_W]    = ack[CW-1 -: HALF_W];
  end

  assign rx_ctl = dst_all[HALF_W-1:0];
  assign tx_ctl = dst_all[DW-1:HALF_W];

  assign rdata = (addr == 2'd0) ? conf :
                 (addr == 2'd3) ? '0   : shadow;
endmodule

// File: rtl/xclk_gctl_chk.sv
module xclk_gctl_chk #(
  parameter int HALF_W = 4
) (
  input logic                bus_clk,
  input logic                bus_rst_n,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [2*HALF_W-1:0] shadow,
  input logic [2*HALF_W-1:0] conf
);
  localparam int DW = 2 * HALF_W;

  assert_bus_reset_clear_R1: assert property (@(posedge bus_clk)
    !bus_rst_n |=> (shadow == '0 && conf == '0));

  assert_rx_alias_keeps_tx_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && addr == 2'd1) |=> $stable(shadow[DW-1:HALF_W]));

  assert_tx_alias_keeps_rx_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && addr == 2'd2) |=> $stable(shadow[HALF_W-1:0]));

  assert_idle_holds_R9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !wr_en |=> $stable(shadow));

  assert_gap_addr_ignored_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && addr == 2'd3) |=> $stable(shadow));
endmodule

bind xclk_gctl xclk_gctl_chk #(.HALF_W(HALF_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .addr(addr),
  .shadow(shadow), .conf(conf)
);

// File: tb/sim_xclk_gctl.sv
`timescale 1ns/100ps
module sim_xclk_gctl;
  localparam int HW = 4;
  localparam int DW = 2 * HW;

  logic bus_clk = 1'b0;
  logic bus_rst_n = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic tx_free = 1'b0, rx_free = 1'b0;
  logic tx_run = 1'b0, rx_run = 1'b0;
  logic tx_man = 1'b0, rx_man = 1'b0;
  logic tx_clk, rx_clk;
  logic tx_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic [HW-1:0] tx_ctl, rx_ctl;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model = '0;

  always #2 bus_clk = ~bus_clk;
  always #11 tx_free = ~tx_free;
  always #15 rx_free = ~rx_free;
  assign tx_clk = tx_run ? tx_free : tx_man;
  assign rx_clk = rx_run ? rx_free : rx_man;

  xclk_gctl #(.HALF_W(HW), .SYNC_STAGES(2)) u0 (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
    .tx_ctl(tx_ctl), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_ctl(rx_ctl)
  );

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] old,
                                          input logic [1:0] a, input logic [DW-1:0] d);
    case (a)
      2'd0: return d;
      2'd1: return {old[DW-1:HW], d[HW-1:0]};
      2'd2: return {d[DW-1:HW], old[HW-1:0]};
      default: return old;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #0.2;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge bus_clk);
    #0.5;
    wr_en = 1'b0;
    model = apply(model, a, d);
  endtask

  task automatic tick_tx();
    @(negedge bus_clk);
    tx_man = 1'b1; #1 tx_man = 1'b0;
  endtask

  task automatic tick_rx();
    @(negedge bus_clk);
    rx_man = 1'b1; #1 rx_man = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'h5EED_1234));
    #1 bus_rst_n = 1'b0;
    tick_tx(); tick_rx();
    idle(4);
    bus_rst_n = 1'b1; tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    idle(2);

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); check(d, 0, "R1 reset readback");
    end
    check(tx_ctl, 0, "R2 tx_ctl after reset");
    check(rx_ctl, 0, "R2 rx_ctl after reset");

    wr(2'd0, 8'hA5);
    rd(2'd1, d); check(d, 8'hA5, "R5 rx alias immediate");
    rd(2'd2, d); check(d, 8'hA5, "R5 tx alias immediate");
    rd(2'd0, d); check(d, 8'h00, "R7 combined not yet confirmed");
    idle(12);
    rd(2'd0, d); check(d, 8'h00, "R8 stopped clocks hold combined");
    check(tx_ctl, 0, "R8 tx_ctl held with clock stopped");

    tick_tx();
    check(tx_ctl, 4'h0, "R6 tx_ctl after one edge");
    tick_tx();
    check(tx_ctl, 4'hA, "R3 R6 tx_ctl after two edges");
    @(negedge bus_clk);
    rd(2'd0, d); check(d, 8'h00, "R7 combined after one bus edge");
    @(negedge bus_clk);
    rd(2'd0, d); check(d, 8'hA0, "R7 combined after two bus edges");

    tick_rx();
    check(rx_ctl, 4'h0, "R6 rx_ctl after one edge");
    tick_rx();
    check(rx_ctl, 4'h5, "R3 R6 rx_ctl after two edges");
    idle(3);
    rd(2'd0, d); check(d, 8'hA5, "R3 combined confirmed");

    wr(2'd1, 8'h3C);
    rd(2'd1, d); check(d, 8'hAC, "R4 rx alias write only rx half");
    wr(2'd2, 8'h71);
    rd(2'd2, d); check(d, 8'h7C, "R4 tx alias write only tx half");
    tick_rx(); tick_rx();
    check(rx_ctl, 4'hC, "R4 rx_ctl from rx alias");
    check(tx_ctl, 4'hA, "R4 tx_ctl untouched without tx edges");
    idle(3);
    rd(2'd0, d); check(d, 8'hAC, "R8 combined tx half held, rx half confirmed");

    wr(2'd3, 8'hFF);
    rd(2'd1, d); check(d, 8'h7C, "R10 unused address write ignored");
    rd(2'd3, d); check(d, 8'h00, "R10 unused address reads zero");

    wr(2'd0, 8'h12);
    wr(2'd0, 8'h34);
    tick_tx(); tick_tx(); tick_rx(); tick_rx();
    idle(3);
    rd(2'd0, d); check(d, 8'h34, "R9 latest write wins");
    check(tx_ctl, 4'h3, "R9 tx_ctl latest");
    check(rx_ctl, 4'h4, "R9 rx_ctl latest");

    tx_rst_n = 1'b0;
    #0.5;
    check(tx_ctl, 4'h0, "R2 tx reset clears tx_ctl");
    check(rx_ctl, 4'h4, "R2 tx reset leaves rx_ctl");
    idle(3);
    rd(2'd0, d); check(d, 8'h04, "R2 combined follows tx reset");
    tx_rst_n = 1'b1;
    tick_tx(); tick_tx();
    check(tx_ctl, 4'h3, "R2 tx_ctl reloads after reset");

    idle(1);
    tx_run = 1'b1; rx_run = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [DW-1:0] v;
      a = 2'($urandom_range(0, 3));
      v = DW'($urandom);
      wr(a, v);
      rd(2'd1, d); check(d, model, "R5 R4 random alias readback");
      rd(2'd3, d); check(d, 0, "R10 random unused read");
      idle($urandom_range(0, 12));
      if (i % 25 == 24) begin
        idle(40);
        rd(2'd0, d); check(d, model, "R9 random settle combined");
        check(tx_ctl, model[DW-1:HW], "R9 random settle tx_ctl");
        check(rx_ctl, model[HW-1:0], "R9 random settle rx_ctl");
      end
    end

    finish_run();
  end
endmodule